// File: doc/BRIEF.md
# Pipelined Unsigned Array Multiplier

This block multiplies two unsigned W-bit operands and returns their full 2W-bit product. The operands pass through a grid of W rows by W cells. Each cell ANDs one multiplicand bit with one multiplier bit and feeds that partial-product bit into a full adder. The adder also takes the sum from the cell above and a carry from the previous row. A register bank follows each row, so the grid works as a pipeline and can take a new operand pair on every clock.

Sums and carries travel in carry-save form from row to row. The multiplicand and multiplier travel with them through the same registers. Each row retires its lowest sum bit as one product bit, and that bit then moves down with the rest of its operand pair. After the last row, a registered carry-propagate adder merges the remaining sums and carries into the upper half of the product. The total latency is W+1 clock edges, and it does not depend on the data. A valid flag moves through the same stages, so the output strobe marks the cycle in which the product of the matching input pair is present.

Top module: `pipe_array_mult`

## Requirements
- R1: When `out_valid` is 1, `out_prod` equals the unsigned product of the operand pair that was accepted with it, and all 2W bits are exact.
- R2: A pair presented with `in_valid`=1 before rising edge e appears with `out_valid`=1 after rising edge e+W (a latency of W+1 edges, which is 6 for W=5). `out_valid` is never 1 at any other time for that pair.
- R3: A new pair may be presented on every consecutive cycle. Each pair produces its own correct product W+1 edges later, and the pairs do not interfere.
- R4: A synchronous reset (`rst`=1 at an edge) clears every pending valid flag. `out_valid` is 0 in the cycle after reset, and pairs in flight when reset is applied never appear at the output.
- R5: A cycle with `in_valid`=0 yields a cycle with `out_valid`=0 exactly W+1 edges later. Valid pairs on either side of that gap are unaffected.
- R6: The all-ones operand pair (2^W-1 times 2^W-1), where carries run through every cell, gives (2^W-1)^2.
- R7: A zero operand on either side gives a product of 0. An operand of 1 passes the other operand through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; clears the valid pipeline |
| in_valid | input | 1 | Marks `in_a`/`in_x` as an operand pair to be multiplied |
| in_a | input | W | Unsigned multiplicand |
| in_x | input | W | Unsigned multiplier |
| out_valid | output | 1 | Marks `out_prod` as the product of a pair accepted W+1 edges earlier |
| out_prod | output | 2W | Unsigned product |

## Verification
An exhaustive back-to-back sweep of all operand pairs shows that every row adds the right shifted partial product and that the final carry-propagate stage is correct. Because each cycle carries a different pair, the sweep also shows that the operands stay aligned with their own partial sums. The corner pairs are zero, one and all-ones, and they separate the cells that never produce carries from those where carries must ripple through every column. A single isolated pulse and a pattern of alternating gaps pin down the exact latency and show that bubbles stay in place. A reset applied while pairs are in flight shows that those pairs are dropped rather than delivered late.

// File: rtl/pam_pkg.sv
package pam_pkg;

  // Full product, used as the reference for the output check.
  function automatic longint unsigned mul_ref(input longint unsigned a,
                                              input longint unsigned x);
    return a * x;
  endfunction

  // Carry-save invariant after row j: the upper sum bits plus the carries,
  // weighted from bit j+1, together with the retired low bits 0..j, equal
  // the multiplicand times the low j+1 bits of the multiplier.
  function automatic logic csa_matches(input longint unsigned s,
                                       input longint unsigned c,
                                       input longint unsigned lo,
                                       input int              j,
                                       input longint unsigned a,
                                       input longint unsigned x);
    longint unsigned mask;
    longint unsigned lhs;
    mask = (64'd1 << (j + 1)) - 64'd1;
    lhs  = (((s >> 1) + c) << (j + 1)) + (lo & mask);
    return lhs == a * (x & mask);
  endfunction

endpackage

// File: rtl/pam_cell.sv
module pam_cell (
  input  logic a_bit,
  input  logic x_bit,
  input  logic sum_in,
  input  logic carry_in,
  output logic sum_out,
  output logic carry_out
);
  logic pp;

  assign pp        = a_bit & x_bit;
  assign sum_out   = pp ^ sum_in ^ carry_in;
  assign carry_out = (pp & sum_in) | (pp & carry_in) | (sum_in & carry_in);
endmodule

// File: rtl/pam_row.sv
module pam_row #(
  parameter int W = 5
) (
  input  logic [W-1:0] a,
  input  logic         xbit,
  input  logic [W-1:0] s_prev,
  input  logic [W-1:0] c_prev,
  output logic [W-1:0] s_next,
  output logic [W-1:0] c_next
);
  // The sum from the row above, moved one column to line up by weight.
  logic [W-1:0] s_aligned;

  assign s_aligned = s_prev >> 1;

  for (genvar i = 0; i < W; i++) begin : g_cell
    pam_cell u_cell (
      .a_bit    (a[i]),
      .x_bit    (xbit),
      .sum_in   (s_aligned[i]),
      .carry_in (c_prev[i]),
      .sum_out  (s_next[i]),
      .carry_out(c_next[i])
    );
  end
endmodule

// File: rtl/pipe_array_mult.sv
module pipe_array_mult #(
  parameter int W = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_x,
  output logic           out_valid,
  output logic [2*W-1:0] out_prod
);
  localparam int LAT = W + 1;
  localparam int CW  = $clog2(LAT + 1) + 1;

  // Per-stage registers: carry-save state, travelling operands, retired bits.
  logic [W-1:0] s_q  [W];
  logic [W-1:0] c_q  [W];
  logic [W-1:0] a_q  [W];
  logic [W-1:0] x_q  [W];
  logic [W-1:0] lo_q [W];
  logic         v_q  [W];

  for (genvar j = 0; j < W; j++) begin : g_stage
    logic [W-1:0] a_in, x_in, s_in, c_in, lo_in;
    logic         v_in;
    logic [W-1:0] s_row, c_row, lo_row;

    if (j == 0) begin : g_first
      assign a_in  = in_a;
      assign x_in  = in_x;
      assign s_in  = '0;
      assign c_in  = '0;
      assign lo_in = '0;
      assign v_in  = in_valid;
    end else begin : g_next
      assign a_in  = a_q[j-1];
      assign x_in  = x_q[j-1];
      assign s_in  = s_q[j-1];
      assign c_in  = c_q[j-1];
      assign lo_in = lo_q[j-1];
      assign v_in  = v_q[j-1];
    end

    pam_row #(.W(W)) u_row (
      .a     (a_in),
      .xbit  (x_in[j]),
      .s_prev(s_in),
      .c_prev(c_in),
      .s_next(s_row),
      .c_next(c_row)
    );

    // The lowest sum bit of row j is final: it becomes product bit j.
    always_comb begin
      lo_row    = lo_in;
      lo_row[j] = s_row[0];
    end

    always_ff @(posedge clk) begin
      if (rst) v_q[j] <= 1'b0;
      else     v_q[j] <= v_in;
      s_q[j]  <= s_row;
      c_q[j]  <= c_row;
      a_q[j]  <= a_in;
      x_q[j]  <= x_in;
      lo_q[j] <= lo_row;
    end

    // R1: the registered carry-save state of every stage still describes
    // the partial product of its own operand pair.
    p_csa_invariant_r1: assert property (@(posedge clk) disable iff (rst)
      v_q[j] |-> pam_pkg::csa_matches(64'(s_q[j]), 64'(c_q[j]), 64'(lo_q[j]),
                                      j, 64'(a_q[j]), 64'(x_q[j])));
  end

  // Final carry-propagate stage: merges the leftover sums and carries.
  logic [W-1:0]   upper;
  logic [2*W-1:0] prod_q;
  logic           ov_q;
  logic [W-1:0]   a_fin, x_fin;

  assign upper = (s_q[W-1] >> 1) + c_q[W-1];

  always_ff @(posedge clk) begin
    if (rst) ov_q <= 1'b0;
    else     ov_q <= v_q[W-1];
    prod_q <= {upper, lo_q[W-1]};
    a_fin  <= a_q[W-1];
    x_fin  <= x_q[W-1];
  end

  assign out_valid = ov_q;
  assign out_prod  = prod_q;

  // Pairs accepted and not yet delivered, kept only for the checks below.
  logic [CW-1:0] inflight;
  logic          accept;

  assign accept = in_valid & ~rst;

  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else     inflight <= inflight + CW'(accept) - CW'(out_valid);
  end

  p_product_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_prod == (2*W)'(pam_pkg::mul_ref(64'(a_fin), 64'(x_fin))));

  p_out_has_source_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> inflight != '0);

  p_inflight_bound_r3: assert property (@(posedge clk) disable iff (rst)
    inflight <= CW'(LAT));

  p_reset_clears_r4: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

endmodule

// File: tb/pipe_array_mult_tb.sv
module pipe_array_mult_tb;
  localparam int W   = 5;
  localparam int LAT = W + 1;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [W-1:0]   in_a = '0;
  logic [W-1:0]   in_x = '0;
  logic           out_valid;
  logic [2*W-1:0] out_prod;

  int ntests = 0;
  int nfail  = 0;

  logic         hv [LAT];
  logic [W-1:0] ha [LAT];
  logic [W-1:0] hx [LAT];
  string        ht [LAT];

  always #2 clk = ~clk;

  pipe_array_mult #(.W(W)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_a     (in_a),
    .in_x     (in_x),
    .out_valid(out_valid),
    .out_prod (out_prod)
  );

  // Shift-and-add reference, written independently of the grid.
  function automatic logic [2*W-1:0] bref(input logic [W-1:0] a,
                                          input logic [W-1:0] x);
    logic [2*W-1:0] acc;
    acc = '0;
    for (int i = 0; i < W; i++)
      if (x[i]) acc = acc + ((2*W)'(a) << i);
    return acc;
  endfunction

  // One cycle: check what is due now, then drive the next input.
  task automatic step(input logic v, input logic [W-1:0] a,
                      input logic [W-1:0] x, input logic r, input string tag);
    logic           ev;
    logic [2*W-1:0] ep;
    @(negedge clk);
    ev = hv[LAT-1];
    ep = ev ? bref(ha[LAT-1], hx[LAT-1]) : '0;
    ntests++;
    if (out_valid !== ev || (ev && out_prod !== ep)) begin
      nfail++;
      $display("FAIL %s: valid=%b prod=%0d expected valid=%b prod=%0d",
               ht[LAT-1], out_valid, out_prod, ev, ep);
    end
    for (int d = LAT - 1; d > 0; d--) begin
      hv[d] = hv[d-1]; ha[d] = ha[d-1]; hx[d] = hx[d-1]; ht[d] = ht[d-1];
    end
    hv[0] = v & ~r; ha[0] = a; hx[0] = x; ht[0] = tag;
    if (r)
      for (int d = 0; d < LAT; d++) hv[d] = 1'b0;
    rst = r; in_valid = v; in_a = a; in_x = x;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < LAT + 1; i++) step(1'b0, '0, '0, 1'b0, tag);
  endtask

  task automatic t_reset_state;
    for (int i = 0; i < 4; i++) step(1'b1, 5'd3, 5'd7, 1'b1, "R4");
    drain("R4");
  endtask

  task automatic t_corners;
    step(1'b1, 5'd0,  5'd0,  1'b0, "R7");
    step(1'b1, 5'd0,  5'd31, 1'b0, "R7");
    step(1'b1, 5'd31, 5'd0,  1'b0, "R7");
    step(1'b1, 5'd1,  5'd22, 1'b0, "R7");
    step(1'b1, 5'd19, 5'd1,  1'b0, "R7");
    step(1'b1, 5'd31, 5'd31, 1'b0, "R6");
    step(1'b1, 5'd30, 5'd31, 1'b0, "R6");
    step(1'b1, 5'd16, 5'd16, 1'b0, "R1");
    drain("R1");
  endtask

  task automatic t_single_pulse;
    step(1'b1, 5'd13, 5'd11, 1'b0, "R2");
    for (int i = 0; i < LAT + 2; i++) step(1'b0, 5'd31, 5'd31, 1'b0, "R2");
  endtask

  task automatic t_bubbles;
    for (int i = 0; i < 16; i++)
      step(i[0], 5'(i * 7 + 3), 5'(31 - i), 1'b0, (i % 2 == 1) ? "R5" : "R1");
    drain("R5");
  endtask

  task automatic t_back_to_back;
    for (int i = 0; i < W; i++) step(1'b1, 5'd31, 5'(1 << i), 1'b0, "R3");
    for (int i = 0; i < W; i++) step(1'b1, 5'(1 << i), 5'd31, 1'b0, "R3");
    for (int i = 0; i < 8; i++)
      step(1'b1, (i % 2 == 1) ? 5'd31 : 5'd0, (i % 2 == 1) ? 5'd0 : 5'd31, 1'b0, "R3");
    drain("R3");
  endtask

  task automatic t_reset_midflight;
    step(1'b1, 5'd9,  5'd27, 1'b0, "R4");
    step(1'b1, 5'd21, 5'd14, 1'b0, "R4");
    step(1'b1, 5'd31, 5'd29, 1'b0, "R4");
    step(1'b1, 5'd5,  5'd6,  1'b1, "R4");
    step(1'b1, 5'd12, 5'd25, 1'b0, "R4");
    drain("R4");
  endtask

  task automatic t_sweep;
    for (int a = 0; a < 32; a++)
      for (int x = 0; x < 32; x++) step(1'b1, 5'(a), 5'(x), 1'b0, "R1");
    drain("R1");
  endtask

  initial begin
    for (int d = 0; d < LAT; d++) begin
      hv[d] = 1'b0; ha[d] = '0; hx[d] = '0; ht[d] = "R4";
    end
    t_reset_state();
    t_corners();
    t_single_pulse();
    t_bubbles();
    t_back_to_back();
    t_reset_midflight();
    t_sweep();
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    ntests++;
    nfail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule